// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block holds the pending-interrupt state of a peripheral. Seven event lines from neighbouring logic each set one flag bit. A seven-bit enable mask decides which pending flags may reach the processor. A single registered interrupt request output is raised while any flag is both pending and enabled.

Software reaches the block through a small register port. One address reads the flags and clears them by writing ones. A second address updates the enable mask in set or clear groups. Other blocks can also clear individual flags directly with clear pulses, for example when a data register is accessed.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags and enables are zero, the flag address reads 0x00, the enable address reads 0x80 and `irq_o` is low.
- R2: A high `evt_set_i[i]` in a cycle sets flag i at the next clock edge. The fixed positions are: bit 6 timer 1, bit 5 timer 2, bit 4 CB1, bit 3 CB2, bit 2 shift register, bit 1 CA1, bit 0 CA2.
- R3: A write to the flag address (0xD) clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged, and such a write never sets a flag.
- R4: A high `evt_clr_i[i]` clears flag i at the next clock edge.
- R5: When a set event and a clear request (either a write or a pulse) reach the same flag in the same cycle, the flag ends up set.
- R6: A write to the enable address (0xE) with data bit 7 = 1 sets each enable bit marked by a 1 in data bits 6:0. Writing 0xFF makes bits 6:0 read back as 0x7F.
- R7: A write to the enable address with data bit 7 = 0 clears each enable bit marked by a 1. Enable bits marked by 0 keep their value.
- R8: A read of the enable address returns 1 in bit 7 and the enable mask in bits 6:0.
- R9: A read of the flag address returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag and its enable bit are both set.
- R10: `irq_o` equals the OR of all flag-and-enable pairs as they stood one cycle earlier, so a pending flag whose enable is clear never raises it.
- R11: Any other address reads 0x00, and a write to it changes neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register, combinational |
| evt_set_i | input | 7 | Per-source set events |
| evt_clr_i | input | 7 | Per-source clear pulses from other blocks |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
A flag can receive a set event in the same cycle as a clear request. That clear request may be a write of ones to the flag address or a clear pulse, and the outcome depends on set taking priority. Random stimulus drives set events, clear pulses and flag-address writes with independent masks every cycle, so overlaps on the same bit arise often. Directed cycles also force the exact collision on one bit. A reference model applies set-after-clear each cycle and predicts the readback and the delayed request line, and every cycle is compared against it.

// File: rtl/irq_flag_ctrl_pkg.sv
package irq_flag_ctrl_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned NUM_SRC = DATA_W - 1;

    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 4'hD;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 4'hE;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_FLAGS  = 2'd1,
        ACC_ENABLE = 2'd2
    } acc_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
        logic               irq;
    } flag_state_t;

    function automatic acc_e decode(input logic [ADDR_W-1:0] a);
        if (a == ADDR_FLAGS)  return ACC_FLAGS;
        if (a == ADDR_ENABLE) return ACC_ENABLE;
        return ACC_NONE;
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_flag_ctrl_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_pulse_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] clr_mask_i,
    input  logic [N-1:0] enable_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    logic [N-1:0] flag_d, flag_q;
    logic         irq_d, irq_q;
    logic [N-1:0] kill;

    // A clear request hits a bit through either path; a set event overrides it.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            always_comb begin
                kill[g]   = clr_pulse_i[g] | (clr_wr_i & clr_mask_i[g]);
                flag_d[g] = set_i[g] | (flag_q[g] & ~kill[g]);
            end
        end
    endgenerate

    always_comb begin
        irq_d = |(flag_q & enable_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            irq_q  <= irq_d;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         polarity_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] enable_o
);
    logic [N-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_i) begin
            if (polarity_i) en_d = en_q | mask_i;
            else            en_d = en_q & ~mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign enable_o = en_q;
endmodule

// File: rtl/irq_readback.sv
module irq_readback
    import irq_flag_ctrl_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  acc_e         acc_i,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] enable_i,
    output logic [N:0]   rdata_o
);
    logic summary;

    always_comb begin
        summary = |(flag_i & enable_i);
        unique case (acc_i)
            ACC_FLAGS:  rdata_o = {summary, flag_i};
            ACC_ENABLE: rdata_o = {1'b1, enable_i};
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0]  evt_set_i,
    input  logic [NUM_SRC-1:0]  evt_clr_i,
    output logic                irq_o
);
    acc_e               acc;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;

    assign acc = decode(reg_addr);

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (evt_set_i),
        .clr_pulse_i (evt_clr_i),
        .clr_wr_i    (reg_wr && acc == ACC_FLAGS),
        .clr_mask_i  (reg_wdata[NUM_SRC-1:0]),
        .enable_i    (en_q),
        .flag_o      (flag_q),
        .irq_o       (irq_o)
    );

    irq_enable_bank #(.N(NUM_SRC)) u_enables (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr && acc == ACC_ENABLE),
        .polarity_i (reg_wdata[DATA_W-1]),
        .mask_i     (reg_wdata[NUM_SRC-1:0]),
        .enable_o   (en_q)
    );

    irq_readback #(.N(NUM_SRC)) u_read (
        .acc_i    (acc),
        .flag_i   (flag_q),
        .enable_i (en_q),
        .rdata_o  (reg_rdata)
    );
endmodule

// File: rtl/irq_flag_ctrl_checker.sv
module irq_flag_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [6:0] evt_set_i,
    input logic [6:0] evt_clr_i,
    input logic       irq_o,
    input logic [6:0] flag_q,
    input logic [6:0] en_q
);
    AST_IRQ_LAGS_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(flag_q & en_q))); // R10

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        |evt_set_i |=> ((flag_q & $past(evt_set_i)) == $past(evt_set_i))); // R5

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_set_i)) == 7'd0)); // R3

    AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_clr_i & ~evt_set_i) |=> ((flag_q & $past(evt_clr_i & ~evt_set_i)) == 7'd0)); // R4

    AST_ENABLE_SET_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'hE && reg_wdata[7]) |=> en_q == ($past(en_q) | $past(reg_wdata[6:0]))); // R6

    AST_ENABLE_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'hE) |-> reg_rdata[7]); // R8
endmodule

bind irq_flag_ctrl irq_flag_ctrl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_set_i (evt_set_i),
    .evt_clr_i (evt_clr_i),
    .irq_o     (irq_o),
    .flag_q    (flag_q),
    .en_q      (en_q)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [6:0] evt_set_i = 7'h00;
    logic [6:0] evt_clr_i = 7'h00;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    logic [6:0] m_flag = 7'h00;
    logic [6:0] m_en   = 7'h00;
    logic       m_irq  = 1'b0;

    always #5 clk = ~clk;

    irq_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set_i(evt_set_i),
        .evt_clr_i(evt_clr_i), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [6:0] f, input logic [6:0] e);
        if (a == 4'hD) return {|(f & e), f};
        if (a == 4'hE) return {1'b1, e};
        return 8'h00;
    endfunction

    function automatic logic [6:0] next_flag(input logic [6:0] f, input logic [6:0] s, input logic [6:0] c,
                                             input logic w, input logic [3:0] a, input logic [7:0] d);
        logic [6:0] k;
        k = c | ((w && a == 4'hD) ? d[6:0] : 7'h00);
        return (f & ~k) | s;
    endfunction

    function automatic logic [6:0] next_en(input logic [6:0] e, input logic w, input logic [3:0] a, input logic [7:0] d);
        if (!(w && a == 4'hD + 4'h1)) return e;
        return d[7] ? (e | d[6:0]) : (e & ~d[6:0]);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Drive inputs after the falling edge, compare outputs, then advance the model at the rising edge.
    task automatic step(input string tag, input logic [3:0] a, input logic w, input logic [7:0] d,
                        input logic [6:0] s, input logic [6:0] c);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; evt_set_i = s; evt_clr_i = c;
        #1;
        check(tag, reg_rdata, exp_read(a, m_flag, m_en));
        check({tag, " irq R10"}, {7'h00, irq_o}, {7'h00, m_irq});
        @(posedge clk);
        m_irq  = |(m_flag & m_en);
        m_flag = next_flag(m_flag, s, c, w, a, d);
        m_en   = next_en(m_en, w, a, d);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] ra;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step("R1 flags after reset", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        step("R1 enables after reset", 4'hE, 1'b0, 8'h00, 7'h00, 7'h00);
        // R2 timer 1 sets bit 6 with enable clear: R10 no request
        step("R2 set timer1", 4'hD, 1'b0, 8'h00, 7'h40, 7'h00);
        step("R2 timer1 pending", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        step("R10 no irq while masked", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        // R6 enable all
        step("R6 write 0xFF", 4'hE, 1'b1, 8'hFF, 7'h00, 7'h00);
        step("R6 reads 0xFF", 4'hE, 1'b0, 8'h00, 7'h00, 7'h00);
        step("R9 summary set", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        // R7 clear group, keep others
        step("R7 clear 0x41", 4'hE, 1'b1, 8'h41, 7'h00, 7'h00);
        step("R7 reads 0xBE", 4'hE, 1'b0, 8'h00, 7'h00, 7'h00);
        step("R9 summary clear", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        // R3 writing ones never sets, zero bits keep
        step("R3 write 0x3F", 4'hD, 1'b1, 8'h3F, 7'h00, 7'h00);
        step("R3 timer1 kept", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        step("R3 clear timer1", 4'hD, 1'b1, 8'h40, 7'h00, 7'h00);
        step("R3 timer1 gone", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        // R5 collisions on CA1 (bit 1)
        step("R5 set+write clear", 4'hD, 1'b1, 8'h02, 7'h02, 7'h00);
        step("R5 set+pulse clear", 4'hD, 1'b0, 8'h00, 7'h02, 7'h02);
        step("R5 CA1 still set", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        // R4 pulse clear
        step("R4 pulse clear CA1", 4'hD, 1'b0, 8'h00, 7'h00, 7'h02);
        step("R4 CA1 cleared", 4'hD, 1'b0, 8'h00, 7'h00, 7'h00);
        // R11 other addresses
        step("R11 write elsewhere", 4'h3, 1'b1, 8'hFF, 7'h00, 7'h00);
        step("R11 read elsewhere", 4'hF, 1'b0, 8'h00, 7'h00, 7'h00);
        step("R11 enables unchanged", 4'hE, 1'b0, 8'h00, 7'h00, 7'h00);
        // Random mix for R2..R11
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 4)
                0: ra = 4'hD;
                1: ra = 4'hE;
                2: ra = 4'hD;
                default: ra = 4'($urandom);
            endcase
            step("R2-mix random", ra, ($urandom % 3) == 0, 8'($urandom),
                 7'($urandom & $urandom), 7'($urandom & $urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule